// File: doc/BRIEF.md
# Fracturable Unsigned Multiplier with Per-Port Register Bypass

This block is a hard multiplier that can be carved up at run-time-static configuration into narrower independent multipliers. It accepts two 36-bit unsigned operands and returns a 72-bit result bus. In full mode the whole bus carries one 36x36 product. In split mode the operand and result buses are cut in half. Each half is an independent unit that either forms one 18x18 product or cuts itself again into two 9x9 multipliers. The lower-numbered child always sits on the less significant bits of both operands and of the result.

Every slice that can be active (the full slice, two half slices, four quarter slices) has a 3-bit register setting. The setting chooses, separately for its A operand, its B operand and its product, whether that port passes through a pipeline flop or goes around it. The designer can therefore trade latency for timing slack port by port. All flops share one clock and clear synchronously. Configuration inputs are treated as static while data flows.

Top module: `fracmul_top`

## Requirements
- R1: All pipeline flops clear synchronously while `rst` is high; with full mode and every register of the full slice enabled, `y` reads zero in the cycle after a reset edge.
- R2: With `mode_split`=0, `y` equals the unsigned product `a*b` over all 72 bits, timed by `reg_full`.
- R3: With `mode_split`=1 and `half_dual[h]`=0, bits `y[36h+35:36h]` equal `a[18h+17:18h]*b[18h+17:18h]`, timed by `reg_half[3h+2:3h]`.
- R4: With `mode_split`=1 and `half_dual[h]`=1, each quarter q in {2h, 2h+1} drives `y[18q+17:18q]` = `a[9q+8:9q]*b[9q+8:9q]`, timed by `reg_qtr[3q+2:3q]`.
- R5: Each 3-bit register setting is ordered {A, B, OUT}: bit 2 registers operand A, bit 1 registers operand B, bit 0 registers the product; a 1 inserts one clock of delay on that port and a 0 routes it combinationally.
- R6: The three register choices of a slice are independent: registering only A gives the product of the previous cycle's A with the current cycle's B, and likewise for the other mixes.
- R7: With every register of the active slices bypassed, `y` follows the operands in the same cycle.
- R8: With every register of the active slices enabled, `y` shows the product of operands applied two cycles earlier.
- R9: The two halves are independent: one half may run as 18x18 while the other runs as two 9x9, each slice with its own register setting.
- R10: Register settings and sub-mode bits of slices that the current mode does not select have no effect on `y`.
- R11: Products are never truncated: all-ones operands yield the full double-width result in every slice width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all pipeline flops |
| rst | input | 1 | Synchronous reset, active high |
| mode_split | input | 1 | 0: one 36x36 multiply; 1: two independent halves |
| half_dual | input | 2 | Per half: 0 one 18x18 multiply, 1 two 9x9 multiplies |
| reg_full | input | 3 | {A,B,OUT} register enables of the full slice |
| reg_half | input | 6 | {A,B,OUT} enables of half h in bits [3h+2:3h] |
| reg_qtr | input | 12 | {A,B,OUT} enables of quarter q in bits [3q+2:3q] |
| a | input | 36 | Operand A, unsigned |
| b | input | 36 | Operand B, unsigned |
| y | output | 72 | Product bus |

## Verification
The sweep walks all eight register settings of the full slice and, for each of the four sub-mode pairs in split mode, eight rotated register settings. The rotation gives every slice a different setting from its neighbours, so a swapped field or a shared enable shows up as a wrong latency in one result lane only. Within each configuration the operand stream mixes all-ones, all-zero and pseudo-random words that change every cycle. All-ones separates truncation faults, zero separates stuck bits, and changing values separate the A, B and product delays from one another. Unselected register and sub-mode bits are set to differing values, so any leak from them disturbs the compared bus.

// File: rtl/fracmul_pkg.sv
package fracmul_pkg;

    // Geometry of the slice tree
    localparam int unsigned REGCFG_W     = 3;
    localparam int unsigned NUM_HALVES   = 2;
    localparam int unsigned QTR_PER_HALF = 2;
    localparam int unsigned NUM_QTRS     = NUM_HALVES * QTR_PER_HALF;

    // Per-slice register setting; packed order fixes the {A,B,OUT} bit positions
    typedef struct packed {
        logic a_reg;
        logic b_reg;
        logic o_reg;
    } regcfg_t;

    typedef enum logic {
        MODE_FULL  = 1'b0,
        MODE_SPLIT = 1'b1
    } top_mode_e;

    typedef enum logic {
        HALF_WIDE = 1'b0,
        HALF_DUAL = 1'b1
    } half_mode_e;

endpackage

// File: rtl/fracmul_stage.sv
// One optionally registered port: the flop always captures, the mux picks
// the flop output or the raw value.
module fracmul_stage #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         use_reg,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            held <= d;
        end
    end

    assign q = use_reg ? held : d;

endmodule

// File: rtl/fracmul_slice.sv
// One multiplier slice with optional A, B and product registers.
module fracmul_slice
    import fracmul_pkg::*;
#(
    parameter int unsigned W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  regcfg_t        cfg,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    localparam int unsigned PW = 2 * W;

    logic [W-1:0]  a_eff;
    logic [W-1:0]  b_eff;
    logic [PW-1:0] a_wide;
    logic [PW-1:0] b_wide;
    logic [PW-1:0] prod;

    fracmul_stage #(.W(W)) u_a_stage (
        .clk     (clk),
        .rst     (rst),
        .use_reg (cfg.a_reg),
        .d       (a),
        .q       (a_eff)
    );

    fracmul_stage #(.W(W)) u_b_stage (
        .clk     (clk),
        .rst     (rst),
        .use_reg (cfg.b_reg),
        .d       (b),
        .q       (b_eff)
    );

    // Zero-extend so the product keeps every bit
    assign a_wide = {{W{1'b0}}, a_eff};
    assign b_wide = {{W{1'b0}}, b_eff};
    assign prod   = a_wide * b_wide;

    fracmul_stage #(.W(PW)) u_p_stage (
        .clk     (clk),
        .rst     (rst),
        .use_reg (cfg.o_reg),
        .d       (prod),
        .q       (p)
    );

endmodule

// File: rtl/fracmul_top.sv
module fracmul_top
    import fracmul_pkg::*;
#(
    parameter int unsigned QW = 9
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               mode_split,
    input  logic [NUM_HALVES-1:0]              half_dual,
    input  logic [REGCFG_W-1:0]                reg_full,
    input  logic [NUM_HALVES*REGCFG_W-1:0]     reg_half,
    input  logic [NUM_QTRS*REGCFG_W-1:0]       reg_qtr,
    input  logic [4*QW-1:0]                    a,
    input  logic [4*QW-1:0]                    b,
    output logic [8*QW-1:0]                    y
);

    localparam int unsigned HW = 2 * QW;   // half operand width
    localparam int unsigned FW = 4 * QW;   // full operand width
    localparam int unsigned PW = 8 * QW;   // product bus width
    localparam int unsigned QP = 2 * QW;   // quarter product width

    logic [PW-1:0] full_p;
    logic [FW-1:0] half_p [NUM_HALVES];
    logic [QP-1:0] qtr_p  [NUM_QTRS];

    top_mode_e  mode;
    half_mode_e hmode [NUM_HALVES];

    fracmul_slice #(.W(FW)) u_full (
        .clk (clk),
        .rst (rst),
        .cfg (regcfg_t'(reg_full)),
        .a   (a),
        .b   (b),
        .p   (full_p)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        fracmul_slice #(.W(HW)) u_half (
            .clk (clk),
            .rst (rst),
            .cfg (regcfg_t'(reg_half[h*REGCFG_W +: REGCFG_W])),
            .a   (a[h*HW +: HW]),
            .b   (b[h*HW +: HW]),
            .p   (half_p[h])
        );
        assign hmode[h] = half_mode_e'(half_dual[h]);
    end

    for (genvar q = 0; q < NUM_QTRS; q++) begin : g_qtr
        fracmul_slice #(.W(QW)) u_qtr (
            .clk (clk),
            .rst (rst),
            .cfg (regcfg_t'(reg_qtr[q*REGCFG_W +: REGCFG_W])),
            .a   (a[q*QW +: QW]),
            .b   (b[q*QW +: QW]),
            .p   (qtr_p[q])
        );
    end

    assign mode = top_mode_e'(mode_split);

    // Result steering: child 0 of any split owns the low bits
    always_comb begin
        y = full_p;
        unique case (mode)
            MODE_FULL: y = full_p;
            MODE_SPLIT: begin
                for (int h = 0; h < NUM_HALVES; h++) begin
                    unique case (hmode[h])
                        HALF_WIDE: y[h*FW +: FW] = half_p[h];
                        HALF_DUAL: begin
                            for (int k = 0; k < QTR_PER_HALF; k++) begin
                                y[h*FW + k*QP +: QP] = qtr_p[h*QTR_PER_HALF + k];
                            end
                        end
                        default: y[h*FW +: FW] = half_p[h];
                    endcase
                end
            end
            default: y = full_p;
        endcase
    end

endmodule

// File: rtl/fracmul_chk.sv
module fracmul_chk
    import fracmul_pkg::*;
#(
    parameter int unsigned QW = 9
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           mode_split,
    input logic [NUM_HALVES-1:0]          half_dual,
    input logic [REGCFG_W-1:0]            reg_full,
    input logic [NUM_HALVES*REGCFG_W-1:0] reg_half,
    input logic [NUM_QTRS*REGCFG_W-1:0]   reg_qtr,
    input logic [4*QW-1:0]                a,
    input logic [4*QW-1:0]                b,
    input logic [8*QW-1:0]                y
);

    localparam int unsigned HW = 2 * QW;
    localparam int unsigned FW = 4 * QW;
    localparam int unsigned PW = 8 * QW;
    localparam int unsigned CW = 1 + NUM_HALVES + REGCFG_W * (1 + NUM_HALVES + NUM_QTRS);

    logic [CW-1:0] cfg_now;
    logic [CW-1:0] cfg_prev;
    logic [1:0]    age;
    logic          cfg_same;
    logic          started;

    logic [PW-1:0] a_full_x, b_full_x;
    logic [FW-1:0] a_h0_x, b_h0_x;
    logic [HW-1:0] a_q3_x, b_q3_x;

    assign cfg_now  = {mode_split, half_dual, reg_full, reg_half, reg_qtr};
    assign cfg_same = (cfg_now == cfg_prev);

    assign a_full_x = {{FW{1'b0}}, a};
    assign b_full_x = {{FW{1'b0}}, b};
    assign a_h0_x   = {{HW{1'b0}}, a[HW-1:0]};
    assign b_h0_x   = {{HW{1'b0}}, b[HW-1:0]};
    assign a_q3_x   = {{QW{1'b0}}, a[4*QW-1 -: QW]};
    assign b_q3_x   = {{QW{1'b0}}, b[4*QW-1 -: QW]};

    // Cycles since reset or a configuration change, saturating at 3
    always_ff @(posedge clk) begin
        cfg_prev <= cfg_now;
        started  <= 1'b1;
        if (rst || !cfg_same) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // R1: reset leaves the fully registered full slice at zero
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        (started && $past(rst) && cfg_same && !mode_split && reg_full == 3'b111)
        |-> (y == '0));

    // R7: fully bypassed full slice is combinational
    a_r7_full_comb: assert property (@(posedge clk) disable iff (rst)
        (!mode_split && reg_full == 3'b000) |-> (y == a_full_x * b_full_x));

    // R8: fully registered full slice has two cycles of latency
    a_r8_full_lat2: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && cfg_same && !mode_split && reg_full == 3'b111)
        |-> (y == $past(a_full_x, 2) * $past(b_full_x, 2)));

    // R3: lower half in 18x18 mode, bypassed, drives the low 36 result bits
    a_r3_half0_comb: assert property (@(posedge clk) disable iff (rst)
        (mode_split && !half_dual[0] && reg_half[2:0] == 3'b000)
        |-> (y[FW-1:0] == a_h0_x * b_h0_x));

    // R6: top quarter with only A registered mixes old A with current B
    a_r6_qtr3_a_only: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && cfg_same && mode_split && half_dual[1] &&
         reg_qtr[4*REGCFG_W-1 -: REGCFG_W] == 3'b100)
        |-> (y[PW-1 -: HW] == $past(a_q3_x) * b_q3_x));

endmodule

bind fracmul_top fracmul_chk #(.QW(QW)) u_chk (.*);

// File: tb/fracmul_top_tb_top.sv
`timescale 1ns/1ps
module fracmul_top_tb_top;

    localparam int unsigned QW = 9;
    localparam int unsigned HW = 2 * QW;
    localparam int unsigned FW = 4 * QW;
    localparam int unsigned PW = 8 * QW;

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_split;
    logic [1:0]    half_dual;
    logic [2:0]    reg_full;
    logic [5:0]    reg_half;
    logic [11:0]   reg_qtr;
    logic [FW-1:0] a, b;
    logic [PW-1:0] y;

    logic [FW-1:0] ha [0:2];
    logic [FW-1:0] hb [0:2];

    int n_chk = 0;
    int n_err = 0;
    int op_idx = 0;

    always #4 clk = ~clk;

    fracmul_top #(.QW(QW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_split (mode_split),
        .half_dual  (half_dual),
        .reg_full   (reg_full),
        .reg_half   (reg_half),
        .reg_qtr    (reg_qtr),
        .a          (a),
        .b          (b),
        .y          (y)
    );

    task automatic check(input logic [PW-1:0] act, input logic [PW-1:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Delay of a port: bit 2 A, bit 1 B, bit 0 OUT (R5)
    function automatic int lat_a(input logic [2:0] c);
        return int'(c[2]) + int'(c[0]);
    endfunction
    function automatic int lat_b(input logic [2:0] c);
        return int'(c[1]) + int'(c[0]);
    endfunction

    function automatic logic [PW-1:0] model();
        logic [PW-1:0] r;
        logic [FW-1:0] av, bv;
        r = '0;
        if (!mode_split) begin
            av = ha[lat_a(reg_full)];
            bv = hb[lat_b(reg_full)];
            r = {{FW{1'b0}}, av} * {{FW{1'b0}}, bv};
        end else begin
            for (int h = 0; h < 2; h++) begin
                if (!half_dual[h]) begin
                    logic [2:0] c;
                    logic [FW-1:0] x1, x2;
                    c  = reg_half[3*h +: 3];
                    x1 = {{HW{1'b0}}, ha[lat_a(c)][HW*h +: HW]};
                    x2 = {{HW{1'b0}}, hb[lat_b(c)][HW*h +: HW]};
                    r[FW*h +: FW] = x1 * x2;
                end else begin
                    for (int k = 0; k < 2; k++) begin
                        logic [2:0] c;
                        logic [HW-1:0] x1, x2;
                        int q;
                        q  = 2*h + k;
                        c  = reg_qtr[3*q +: 3];
                        x1 = {{QW{1'b0}}, ha[lat_a(c)][QW*q +: QW]};
                        x2 = {{QW{1'b0}}, hb[lat_b(c)][QW*q +: QW]};
                        r[HW*q +: HW] = x1 * x2;
                    end
                end
            end
        end
        return r;
    endfunction

    // Advance one cycle: new operands at the falling edge, history shifted
    task automatic step();
        logic [FW-1:0] na, nb;
        @(negedge clk);
        case (op_idx % 5)
            0: begin na = '1; nb = '1; end
            1: begin na = '0; nb = FW'({$urandom, $urandom}); end
            default: begin
                na = FW'({$urandom, $urandom});
                nb = FW'({$urandom, $urandom});
            end
        endcase
        op_idx++;
        ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = na;
        hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = nb;
        a = na;
        b = nb;
        #1;
    endtask

    task automatic run_cfg(input string req);
        step();
        step();
        for (int i = 0; i < 6; i++) begin
            step();
            check(y, model(), req);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1;
        mode_split = 1'b0;
        half_dual = 2'b00;
        reg_full = 3'b111;
        reg_half = 6'b0;
        reg_qtr = 12'b0;
        a = '1;
        b = '1;
        for (int i = 0; i < 3; i++) begin
            ha[i] = '0;
            hb[i] = '0;
        end

        // R1: flops clear while reset is held
        repeat (2) @(negedge clk);
        check(y, '0, "R1 reset clear");
        @(negedge clk);
        check(y, '0, "R1 reset hold");
        rst = 1'b0;

        // Full mode, every register pattern; unused fields scrambled (R10)
        for (int p = 0; p < 8; p++) begin
            string lbl;
            mode_split = 1'b0;
            reg_full   = 3'(p);
            half_dual  = 2'(p + 1);
            reg_half   = 6'($urandom);
            reg_qtr    = 12'($urandom);
            lbl = (p == 0) ? "R2 R5 R7 R10" : (p == 7) ? "R2 R5 R8 R10" : "R2 R5 R6 R10";
            run_cfg(lbl);
        end

        // Split mode: each sub-mode pair with rotated per-slice settings
        for (int hd = 0; hd < 4; hd++) begin
            for (int p = 0; p < 8; p++) begin
                string lbl;
                mode_split = 1'b1;
                half_dual  = 2'(hd);
                reg_full   = 3'(7 - p);
                for (int h = 0; h < 2; h++) reg_half[3*h +: 3] = 3'((p + 5*h) % 8);
                for (int q = 0; q < 4; q++) reg_qtr[3*q +: 3] = 3'((p + 3*q) % 8);
                case (hd)
                    0: lbl = "R3 R5 R6 R10";
                    3: lbl = "R4 R5 R6 R10";
                    default: lbl = "R3 R4 R9 R10";
                endcase
                run_cfg(lbl);
            end
        end

        // R11: all-ones operands, every width, all bypassed
        @(negedge clk);
        a = '1;
        b = '1;
        mode_split = 1'b0;
        reg_full = 3'b000;
        #1;
        check(y, {{FW{1'b0}}, {FW{1'b1}}} * {{FW{1'b0}}, {FW{1'b1}}}, "R11 full width");
        mode_split = 1'b1;
        half_dual = 2'b01;
        reg_half = 6'b0;
        reg_qtr = 12'b0;
        #1;
        begin
            logic [FW-1:0] hp;
            logic [HW-1:0] qp;
            hp = {{HW{1'b0}}, {HW{1'b1}}} * {{HW{1'b0}}, {HW{1'b1}}};
            qp = {{QW{1'b0}}, {QW{1'b1}}} * {{QW{1'b0}}, {QW{1'b1}}};
            check(y, {hp, qp, qp}, "R11 R9 mixed widths");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule